// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital front end of a 5-bit step attenuator. It produces the attenuation code that drives the switched pad array. Each code bit switches one pad. Code 0 is the reference (minimum-loss) setting and code 31 is the full 15.5 dB.

The code can come from either of two control paths, and the mode input picks one. The first is a 5-wire parallel word, used in direct or latched fashion. The second is a 3-wire serial port: a serial clock, a data line and a latch enable. This port loads a 6-bit shift register, which sits behind a transparent latch. The serial clock, serial data and latch-enable lines come from outside the chip. They pass through two-flop synchronisers and are then used in the system clock domain. The rising edge of the serial clock is found by edge detection. The mode pin, the parallel word and the power-up select pin are treated as static levels and sampled directly. Reset stands in for power-up: the first clock after reset is released loads a defined initial code, chosen by the mode pin, the synchronised latch enable and the power-up select pin.

A small state machine runs the latch. Its states are ST_BOOT, ST_HOLD, ST_PASS and ST_FAULT.
- ST_BOOT is entered while reset is asserted. It loads the power-up code and then always moves to ST_HOLD.
- When the synchronised latch enable is low, ST_HOLD, ST_PASS and ST_FAULT all go to ST_HOLD.
- When latch enable is high and the serial word's start bit is high while serial mode is selected, these states go to ST_FAULT.
- When latch enable is high otherwise, they go to ST_PASS.

Top module: `step_atten_ctrl`

## Requirements
- R1: `ser_sel_i` low makes the parallel pins the source of the transparent latch. `ser_sel_i` high makes bits [4:0] of the serial register the source, and changes on the parallel pins then have no effect.
- R2: `atten_o` bit 4 weighs 8 dB, bit 3 weighs 4 dB, bit 2 weighs 2 dB, bit 1 weighs 1 dB and bit 0 weighs 0.5 dB. Code 0 is the reference state and code 31 is 15.5 dB.
- R3: On each synchronised rising edge of `sclk_i`, the 6-bit serial register shifts left and takes the synchronised `sdata_i` into bit 0. The first bit sent therefore ends in bit 5 (the start bit), and bits 4..0 hold the code MSB first. Shifting takes place whatever the latch-enable level.
- R4: In serial mode, while the synchronised `le_i` is high and the start bit is 0, `atten_o` follows bits [4:0] of the serial register.
- R5: While the synchronised `le_i` is low, `atten_o` holds its value. A high-then-low pulse on `le_i` captures the selected source as it stood in the last cycle that latch enable was seen high.
- R6: In parallel mode with `le_i` held high (direct mode), `atten_o` follows `par_code_i`.
- R7: Power-up in serial mode loads `atten_o` from `par_code_i`.
- R8: Power-up in parallel mode with `le_i` low loads code 0 when `pwrup_sel_i` is 0, and code 5'b10000 (8 dB) when it is 1.
- R9: Power-up in parallel mode with `le_i` high loads `par_code_i`. `pwrup_sel_i` has no effect, then or afterwards.
- R10: If the start bit is 1 while the latch is transparent in serial mode, `atten_o` keeps its previous value and `word_err_o` goes to 1. `word_err_o` returns to 0 when a word with a start bit of 0 passes the latch, and latch-enable low leaves it unchanged.
- R11: `le_i`, `sclk_i` and `sdata_i` act two system-clock edges after the edge that samples them. `ser_sel_i`, `par_code_i` and `pwrup_sel_i` act on the edge that samples them.
- R12: Reset is synchronous and active high. While it is asserted, `atten_o` is 0 and `word_err_o` is 0. The first edge with reset low loads the power-up code (R7 to R9) and preloads the serial register with a 0 start bit followed by that code, so opening the latch does not disturb the power-up code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset, standing in for power-up |
| ser_sel_i | input | 1 | Interface select: 0 parallel, 1 serial |
| le_i | input | 1 | Latch enable (asynchronous) |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| par_code_i | input | 5 | Parallel attenuation word, also used as power-up value |
| pwrup_sel_i | input | 1 | Power-up select for parallel mode with latch enable low |
| atten_o | output | 5 | Attenuation code to the pad array |
| word_err_o | output | 1 | Start-bit error flag |

## Verification
Expected timing:
- A latch-enable, serial-clock or serial-data change that the bench applies before clock edge n reaches `atten_o` only after edge n+2. This is the two synchroniser flops; the serial-clock rise also needs the previous level from one flop further back.
- Parallel-word and mode changes show after edge n itself.
- The power-up code appears after the first edge with reset low.

The bench keeps a three-deep history of the asynchronous inputs. Its reference model reads the entry from two edges back. It drives every input on the falling clock edge and compares `atten_o` and `word_err_o` with the model at every falling edge. Directed checks are placed only after the waits needed for that latency.

// File: rtl/atten_pkg.sv
package atten_pkg;

    // Latch controller states
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,   // reset held; power-up code loaded on release
        ST_HOLD  = 2'd1,   // latch opaque
        ST_PASS  = 2'd2,   // latch transparent, source accepted
        ST_FAULT = 2'd3    // latch transparent, serial start bit set
    } latch_state_t;

endpackage

// File: rtl/atten_in_sync.sv
module atten_in_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    // Free-running chain: it settles during reset so that the
    // power-up decision sees the real latch-enable level.
    always_ff @(posedge clk) begin
        stg[0] <= d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/atten_ser_shreg.sv
module atten_ser_shreg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= load_val_i;
        end else if (shift_i) begin
            q_o <= {q_o[W-2:0], din_i};
        end
    end

    // R3
    shift_left_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && shift_i) |=> (q_o == {$past(q_o[W-2:0]), $past(din_i)}));

endmodule

// File: rtl/atten_latch_fsm.sv
module atten_latch_fsm
    import atten_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_i,
    input  logic              le_s_i,
    input  logic [CODE_W-1:0] par_code_i,
    input  logic              pwrup_sel_i,
    input  logic [CODE_W:0]   sr_word_i,
    output logic              boot_load_o,
    output logic [CODE_W-1:0] boot_code_o,
    output logic [CODE_W-1:0] code_o,
    output logic              err_o
);

    localparam logic [CODE_W-1:0] PUP_HI = CODE_W'(1) << (CODE_W - 1);

    latch_state_t state_q, state_nx;
    logic         start_bad;
    logic [CODE_W-1:0] src_code;

    assign start_bad   = ser_sel_i && sr_word_i[CODE_W];
    assign src_code    = ser_sel_i ? sr_word_i[CODE_W-1:0] : par_code_i;
    assign boot_load_o = (state_q == ST_BOOT);

    // Power-up code selection
    always_comb begin
        if (ser_sel_i || le_s_i) begin
            boot_code_o = par_code_i;
        end else if (pwrup_sel_i) begin
            boot_code_o = PUP_HI;
        end else begin
            boot_code_o = '0;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_BOOT:  state_nx = ST_HOLD;
            ST_HOLD:  state_nx = !le_s_i ? ST_HOLD
                               : (start_bad ? ST_FAULT : ST_PASS);
            ST_PASS:  state_nx = !le_s_i ? ST_HOLD
                               : (start_bad ? ST_FAULT : ST_PASS);
            ST_FAULT: state_nx = !le_s_i ? ST_HOLD
                               : (start_bad ? ST_FAULT : ST_PASS);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= '0;
            err_o  <= 1'b0;
        end else if (state_q == ST_BOOT) begin
            code_o <= boot_code_o;
            err_o  <= 1'b0;
        end else begin
            unique case (state_nx)
                ST_PASS: begin
                    code_o <= src_code;
                    err_o  <= 1'b0;
                end
                ST_FAULT: err_o <= 1'b1;
                default: ;
            endcase
        end
    end

    // R5
    opaque_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BOOT && !le_s_i) |=> $stable(code_o));

    // R6
    direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BOOT && le_s_i && !ser_sel_i) |=> (code_o == $past(par_code_i)));

    // R4
    serial_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BOOT && le_s_i && ser_sel_i && !sr_word_i[CODE_W])
        |=> (code_o == $past(sr_word_i[CODE_W-1:0])));

    // R10
    bad_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BOOT && le_s_i && start_bad) |=> ($stable(code_o) && err_o));

    // R8
    pwrup_par_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT && !ser_sel_i && !le_s_i)
        |=> (code_o == ($past(pwrup_sel_i) ? PUP_HI : '0)));

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
    parameter int CODE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_i,
    input  logic              le_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic [CODE_W-1:0] par_code_i,
    input  logic              pwrup_sel_i,
    output logic [CODE_W-1:0] atten_o,
    output logic              word_err_o
);

    localparam int SR_W = CODE_W + 1;

    logic [2:0]        raw_lines, syn_lines;
    logic              le_s, sclk_s, sdata_s, sclk_prev, sclk_rise;
    logic              boot_load;
    logic [CODE_W-1:0] boot_code;
    logic [SR_W-1:0]   sr_word;

    assign raw_lines = {le_i, sclk_i, sdata_i};

    atten_in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (raw_lines),
        .q_o (syn_lines)
    );

    assign le_s    = syn_lines[2];
    assign sclk_s  = syn_lines[1];
    assign sdata_s = syn_lines[0];

    always_ff @(posedge clk) begin
        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev;

    atten_ser_shreg #(.W(SR_W)) u_shreg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (boot_load),
        .load_val_i ({1'b0, boot_code}),
        .shift_i    (sclk_rise),
        .din_i      (sdata_s),
        .q_o        (sr_word)
    );

    atten_latch_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ser_sel_i   (ser_sel_i),
        .le_s_i      (le_s),
        .par_code_i  (par_code_i),
        .pwrup_sel_i (pwrup_sel_i),
        .sr_word_i   (sr_word),
        .boot_load_o (boot_load),
        .boot_code_o (boot_code),
        .code_o      (atten_o),
        .err_o       (word_err_o)
    );

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (atten_o == '0 && !word_err_o));

endmodule

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_sel = 1'b0;
    logic       le = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [4:0] par_code = 5'd0;
    logic       pwrup_sel = 1'b0;
    logic [4:0] atten;
    logic       werr;

    step_atten_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .ser_sel_i   (ser_sel),
        .le_i        (le),
        .sclk_i      (sclk),
        .sdata_i     (sdata),
        .par_code_i  (par_code),
        .pwrup_sel_i (pwrup_sel),
        .atten_o     (atten),
        .word_err_o  (werr)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R12";
    bit    started = 0;
    bit    done = 0;

    // Reference model state
    int m_code = 0, m_err = 0, m_sr = 0;
    bit m_boot = 1;
    bit lh [4];
    bit ch [4];
    bit dh [4];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: asynchronous lines act two edges after sampling
    always @(posedge clk) begin
        for (int i = 3; i > 0; i--) begin
            lh[i] = lh[i-1];
            ch[i] = ch[i-1];
            dh[i] = dh[i-1];
        end
        lh[0] = le;
        ch[0] = sclk;
        dh[0] = sdata;
        if (rst) begin
            m_code = 0; m_err = 0; m_sr = 0; m_boot = 1;
        end else if (m_boot) begin
            if (ser_sel || lh[2]) m_code = int'(par_code);
            else m_code = pwrup_sel ? 16 : 0;
            m_sr = m_code; m_err = 0; m_boot = 0;
        end else begin
            if (lh[2]) begin
                if (ser_sel && m_sr >= 32) m_err = 1;
                else begin
                    m_code = ser_sel ? (m_sr % 32) : int'(par_code);
                    m_err = 0;
                end
            end
            if (ch[2] && !ch[3]) m_sr = (m_sr * 2 + int'(dh[2])) % 64;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check(phase, int'(atten), m_code);
            check(phase, int'(werr), m_err);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit s, input bit l, input bit p, input int code);
        ser_sel = s; le = l; pwrup_sel = p; par_code = 5'(code);
        rst = 1'b1;
        wait_n(5);
        rst = 1'b0;
        wait_n(1);
    endtask

    task automatic send(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) begin
            sdata = w[i];
            wait_n(2);
            sclk = 1'b1;
            wait_n(3);
            sclk = 1'b0;
            wait_n(3);
        end
    endtask

    task automatic pulse_le();
        le = 1'b1;
        wait_n(4);
        le = 1'b0;
        wait_n(4);
    endtask

    initial begin
        // R12 reset state, then R8 power-up with select 1
        phase = "R12";
        ser_sel = 0; le = 0; pwrup_sel = 1; par_code = 5'd7;
        wait_n(5);
        check("R12", int'(atten), 0);
        check("R12", int'(werr), 0);
        rst = 1'b0;
        phase = "R8";
        wait_n(1);
        check("R8", int'(atten), 16);
        do_reset(0, 0, 0, 7);
        check("R8", int'(atten), 0);

        // R9 parallel power-up with latch enable high
        phase = "R9";
        do_reset(0, 1, 0, 21);
        check("R9", int'(atten), 21);
        pwrup_sel = 1; wait_n(5);
        check("R9", int'(atten), 21);
        do_reset(0, 1, 1, 9);
        check("R9", int'(atten), 9);

        // R6 direct mode, R2 extremes
        phase = "R6";
        par_code = 5'd31; wait_n(1);
        check("R2", int'(atten), 31);
        par_code = 5'd1; wait_n(1);
        check("R6", int'(atten), 1);
        par_code = 5'd16; wait_n(1);
        check("R6", int'(atten), 16);

        // R5 latched parallel mode
        phase = "R5";
        le = 0; wait_n(4);
        par_code = 5'd5; wait_n(3);
        check("R5", int'(atten), 16);
        pulse_le();
        check("R5", int'(atten), 5);
        par_code = 5'd0; wait_n(3);
        check("R5", int'(atten), 5);

        // R7 serial power-up, R12 register preload
        phase = "R7";
        do_reset(1, 0, 0, 13);
        check("R7", int'(atten), 13);
        le = 1; wait_n(4);
        check("R12", int'(atten), 13);
        le = 0; wait_n(4);

        // R3 shifting while latch opaque, R4 capture
        phase = "R3";
        send(6'b010110);
        check("R3", int'(atten), 13);
        pulse_le();
        check("R4", int'(atten), 22);

        // R4 transparent while shifting (intermediate start bits fault)
        phase = "R4";
        le = 1; wait_n(4);
        send(6'b000011);
        wait_n(3);
        check("R4", int'(atten), 3);
        check("R4", int'(werr), 0);
        le = 0; wait_n(4);

        // R10 start bit set
        phase = "R10";
        send(6'b100101);
        pulse_le();
        check("R10", int'(atten), 3);
        check("R10", int'(werr), 1);
        send(6'b001001);
        check("R10", int'(werr), 1);
        pulse_le();
        check("R10", int'(atten), 9);
        check("R10", int'(werr), 0);

        // R1 interface selection
        phase = "R1";
        le = 1; par_code = 5'd30; wait_n(4);
        check("R1", int'(atten), 9);
        ser_sel = 0; wait_n(1);
        check("R1", int'(atten), 30);
        ser_sel = 1; wait_n(1);
        check("R1", int'(atten), 9);

        // R11 latency of latch enable
        phase = "R11";
        ser_sel = 0; wait_n(2);
        le = 0; par_code = 5'd4; wait_n(1);
        check("R11", int'(atten), 4);
        par_code = 5'd6; wait_n(1);
        check("R11", int'(atten), 6);
        par_code = 5'd8; wait_n(1);
        check("R11", int'(atten), 6);
        wait_n(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule